// File: doc/BRIEF.md
# Coalescing Write Buffer

This block sits between a write-through data cache and the next level of memory. It holds stores that have left the CPU but have not yet reached memory. The CPU keeps executing while the buffered writes drain in the background. Each slot covers one whole block and tracks which of its bytes are valid. A later store to a block that already has a slot is folded into that slot, so it takes no new one.

A load lookup port searches every slot in the same cycle. If the buffer holds every byte the load asks for, the data is forwarded from the buffer. If the buffer holds only some of those bytes, the load is told to wait. The buffer then drains until the block has left, and after that memory holds current data.

A single memory request port is shared by two kinds of traffic: read misses from the cache and write drains from the buffer. A read miss always takes the port, even when older writes are still queued. Write drains start under any of three conditions:
- occupancy reaches a programmable high-water mark;
- a load is waiting on a partial match;
- the buffer has been quiet for a set number of cycles.

Top module: `cwb_buffer`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1, `mem_valid` is 0, and any load returns `ld_hit`=0 and `ld_wait`=0.
- R2: A store to a block with no slot is accepted into a new slot. Slots drain to memory in the order they were allocated.
- R3: A store to a block that already has a slot merges into that slot without using another one. Byte i of the block is data bits [8i+7:8i] and is selected by enable bit i. Each enabled byte overwrites the buffered byte and becomes valid, and all other bytes are kept.
- R4: A load whose block has a slot holding every byte in `ld_be` gives `ld_hit`=1, and `ld_data` carries the buffered bytes. A load to a block with no slot gives `ld_hit`=0 and `ld_wait`=0.
- R5: A load whose block has a slot that lacks one or more requested bytes gives `ld_wait`=1 and `ld_hit`=0. This forces draining even below the high-water mark. Once that slot has drained, the same load gives `ld_hit`=0 and `ld_wait`=0.
- R6: When every slot is occupied, a store to a block with no slot sees `st_ready`=0 and is not taken. A store that merges into an existing slot is still accepted.
- R7: A drain is requested whenever occupancy is non-zero and at least `cfg_hwm`. No drain is requested below the mark unless R5 or R8 applies.
- R8: After IDLE_CYC consecutive cycles with no `rd_req` and no accepted store, a non-empty buffer requests a drain.
- R9: While `rd_req` is 1, the memory port carries the read:
  - `mem_valid`=1, `mem_we`=0, `mem_addr`=`rd_blk`, `mem_be` all ones;
  - `rd_gnt` equals `mem_ready`;
  - no write drain is issued in that cycle.
- R10: A write drain presents the oldest slot:
  - `mem_we`=1, `mem_addr` is the slot's block, `mem_be` is its byte-valid mask, `mem_wdata` is its data;
  - the slot is freed in the cycle `mem_ready` is 1.
- R11: A store to the block whose slot is being freed in that same cycle goes into a fresh slot that holds only the new bytes. Nothing is merged into the departing slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hwm | input | $clog2(ENTRIES+1) | High-water mark for occupancy-triggered draining |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_blk | input | AW | Store block address |
| st_be | input | NB | Store byte enables |
| st_data | input | 8*NB | Store data, byte i at bits [8i+7:8i] |
| ld_valid | input | 1 | Load lookup request |
| ld_blk | input | AW | Load block address |
| ld_be | input | NB | Bytes the load needs |
| ld_hit | output | 1 | All needed bytes forwarded from the buffer |
| ld_wait | output | 1 | Partial match; load must retry after drain |
| ld_data | output | 8*NB | Forwarded block data |
| rd_req | input | 1 | Read miss request from the cache |
| rd_blk | input | AW | Read miss block address |
| rd_gnt | output | 1 | Read miss taken by memory this cycle |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write drain, 0 = read |
| mem_addr | output | AW | Memory block address |
| mem_be | output | NB | Memory byte enables |
| mem_wdata | output | 8*NB | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |

## Verification
The bench builds the block with four slots, four-byte blocks, an 8-bit block address and an idle threshold of six cycles. With four slots, the full-buffer stall and the merge-while-full case are reached with a handful of stores. The short idle threshold lets the bench count the exact cycle at which the quiet-time drain begins. Holding `mem_ready` low keeps the contents stable for lookups. Opening it in chosen cycles makes the drain-versus-store collision and the drain ordering directly observable.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  // Memory port owner in a given cycle
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_READ  = 2'd1,
    PORT_DRAIN = 2'd2
  } port_op_e;
endpackage

// File: rtl/cwb_match.sv
module cwb_match #(
  parameter int E  = 8,
  parameter int AW = 28
) (
  input  logic [E-1:0]         vld,
  input  logic [E-1:0][AW-1:0] blk,
  input  logic [AW-1:0]        qry,
  output logic [E-1:0]         hit
);
  for (genvar g = 0; g < E; g++) begin : g_cmp
    assign hit[g] = vld[g] && (blk[g] == qry);
  end
endmodule

// File: rtl/cwb_arb.sv
module cwb_arb
  import cwb_pkg::*;
#(
  parameter int AW       = 28,
  parameter int NB       = 4,
  parameter int CW       = 4,
  parameter int IDLE_CYC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   count,
  input  logic [CW-1:0]   cfg_hwm,
  input  logic            ld_wait,
  input  logic            st_acc,
  input  logic            rd_req,
  input  logic [AW-1:0]   rd_blk,
  input  logic [AW-1:0]   head_blk,
  input  logic [NB-1:0]   head_bv,
  input  logic [8*NB-1:0] head_data,
  input  logic            mem_ready,
  output logic            mem_valid,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [NB-1:0]   mem_be,
  output logic [8*NB-1:0] mem_wdata,
  output logic            rd_gnt,
  output logic            drain_fire
);
  localparam int IW = $clog2(IDLE_CYC + 1);

  logic [IW-1:0] idle_q;
  logic          idle_hit;
  logic          drain_want;
  port_op_e      op;

  assign idle_hit = (idle_q >= IW'(IDLE_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n)                idle_q <= '0;
    else if (st_acc || rd_req) idle_q <= '0;
    else if (!idle_hit)        idle_q <= idle_q + 1'b1;
  end

  assign drain_want = (count != '0) && ((count >= cfg_hwm) || ld_wait || idle_hit);

  always_comb begin
    if (rd_req)          op = PORT_READ;
    else if (drain_want) op = PORT_DRAIN;
    else                 op = PORT_IDLE;
  end

  assign mem_valid  = (op != PORT_IDLE);
  assign mem_we     = (op == PORT_DRAIN);
  assign mem_addr   = (op == PORT_READ) ? rd_blk : head_blk;
  assign mem_be     = (op == PORT_READ) ? '1 : head_bv;
  assign mem_wdata  = mem_we ? head_data : '0;
  assign rd_gnt     = (op == PORT_READ) && mem_ready;
  assign drain_fire = mem_we && mem_ready;
endmodule

// File: rtl/cwb_buffer.sv
module cwb_buffer #(
  parameter int ENTRIES  = 8,
  parameter int NB       = 4,
  parameter int AW       = 28,
  parameter int IDLE_CYC = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [$clog2(ENTRIES+1)-1:0]   cfg_hwm,
  input  logic                           st_valid,
  output logic                           st_ready,
  input  logic [AW-1:0]                  st_blk,
  input  logic [NB-1:0]                  st_be,
  input  logic [8*NB-1:0]                st_data,
  input  logic                           ld_valid,
  input  logic [AW-1:0]                  ld_blk,
  input  logic [NB-1:0]                  ld_be,
  output logic                           ld_hit,
  output logic                           ld_wait,
  output logic [8*NB-1:0]                ld_data,
  input  logic                           rd_req,
  input  logic [AW-1:0]                  rd_blk,
  output logic                           rd_gnt,
  output logic                           mem_valid,
  output logic                           mem_we,
  output logic [AW-1:0]                  mem_addr,
  output logic [NB-1:0]                  mem_be,
  output logic [8*NB-1:0]                mem_wdata,
  input  logic                           mem_ready
);
  localparam int DW = 8 * NB;
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CW = $clog2(ENTRIES + 1);

  // Byte-lane arithmetic
  function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] old_d,
                                                input logic [DW-1:0] new_d,
                                                input logic [NB-1:0] be);
    logic [DW-1:0] r;
    r = old_d;
    for (int b = 0; b < NB; b++)
      if (be[b]) r[8*b +: 8] = new_d[8*b +: 8];
    return r;
  endfunction

  function automatic logic covers(input logic [NB-1:0] bv, input logic [NB-1:0] be);
    return (bv & be) == be;
  endfunction

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  // Slot storage
  logic [ENTRIES-1:0]          e_vld;
  logic [ENTRIES-1:0][AW-1:0]  e_blk;
  logic [ENTRIES-1:0][NB-1:0]  e_bv;
  logic [ENTRIES-1:0][DW-1:0]  e_data;
  logic [PW-1:0]               head, tail;
  logic [CW-1:0]               count;

  // Named internal events
  logic               full;
  logic               drain_fire;
  logic               st_acc;
  logic               merge_hit;
  logic               alloc;
  logic [ENTRIES-1:0] smatch, smatch_eff, lmatch, head_mask;
  logic [PW-1:0]      msel, lsel;
  logic               l_any;

  cwb_match #(.E(ENTRIES), .AW(AW)) u_smatch (
    .vld(e_vld), .blk(e_blk), .qry(st_blk), .hit(smatch));

  cwb_match #(.E(ENTRIES), .AW(AW)) u_lmatch (
    .vld(e_vld), .blk(e_blk), .qry(ld_blk), .hit(lmatch));

  assign full       = (count == CW'(ENTRIES));
  assign head_mask  = drain_fire ? (ENTRIES'(1) << head) : '0;
  assign smatch_eff = smatch & ~head_mask;
  assign merge_hit  = |smatch_eff;
  assign st_ready   = merge_hit || !full;
  assign st_acc     = st_valid && st_ready;
  assign alloc      = st_acc && !merge_hit;

  always_comb begin
    msel = '0;
    lsel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (smatch_eff[i]) msel = PW'(i);
      if (lmatch[i])     lsel = PW'(i);
    end
  end

  assign l_any   = |lmatch;
  assign ld_hit  = ld_valid && l_any && covers(e_bv[lsel], ld_be);
  assign ld_wait = ld_valid && l_any && !covers(e_bv[lsel], ld_be);
  assign ld_data = e_data[lsel];

  cwb_arb #(.AW(AW), .NB(NB), .CW(CW), .IDLE_CYC(IDLE_CYC)) u_arb (
    .clk(clk), .rst_n(rst_n), .count(count), .cfg_hwm(cfg_hwm),
    .ld_wait(ld_wait), .st_acc(st_acc), .rd_req(rd_req), .rd_blk(rd_blk),
    .head_blk(e_blk[head]), .head_bv(e_bv[head]), .head_data(e_data[head]),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .rd_gnt(rd_gnt), .drain_fire(drain_fire));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld  <= '0;
      e_blk  <= '0;
      e_bv   <= '0;
      e_data <= '0;
      head   <= '0;
      tail   <= '0;
      count  <= '0;
    end else begin
      if (drain_fire) begin
        e_vld[head] <= 1'b0;
        head        <= ptr_next(head);
      end
      if (st_acc && merge_hit) begin
        e_bv[msel]   <= e_bv[msel] | st_be;
        e_data[msel] <= merge_bytes(e_data[msel], st_data, st_be);
      end else if (alloc) begin
        e_vld[tail]  <= 1'b1;
        e_blk[tail]  <= st_blk;
        e_bv[tail]   <= st_be;
        e_data[tail] <= st_data;
        tail         <= ptr_next(tail);
      end
      if (alloc && !drain_fire)      count <= count + 1'b1;
      else if (!alloc && drain_fire) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/cwb_chk.sv
module cwb_chk #(
  parameter int E  = 8,
  parameter int AW = 28,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_ready,
  input logic          rd_req,
  input logic [AW-1:0] rd_blk,
  input logic          rd_gnt,
  input logic          mem_valid,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready,
  input logic [CW-1:0] count,
  input logic          alloc,
  input logic          drain_fire
);
  // R9
  rd_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (mem_valid && !mem_we && mem_addr == rd_blk && rd_gnt == mem_ready));

  // R6
  stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |-> (count == CW'(E)));

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(E));

  // R10
  drain_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (count != '0));

  // R10
  drain_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_fire && !alloc) |=> (count == $past(count) - 1'b1));

  // R3
  merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && !alloc && !drain_fire) |=> (count == $past(count)));
endmodule

bind cwb_buffer cwb_chk #(.E(ENTRIES), .AW(AW), .CW($clog2(ENTRIES+1))) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .rd_req(rd_req), .rd_blk(rd_blk), .rd_gnt(rd_gnt), .mem_valid(mem_valid),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready),
  .count(count), .alloc(alloc), .drain_fire(drain_fire));

// File: tb/sim_cwb_buffer.sv
`timescale 1ns/1ps
module sim_cwb_buffer;
  localparam int E  = 4;
  localparam int NB = 4;
  localparam int AW = 8;
  localparam int IC = 6;
  localparam int CW = $clog2(E + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cfg_hwm = 3'd7;
  logic st_valid = 1'b0, st_ready;
  logic [AW-1:0] st_blk = '0;
  logic [NB-1:0] st_be = '0;
  logic [31:0] st_data = '0;
  logic ld_valid = 1'b0, ld_hit, ld_wait;
  logic [AW-1:0] ld_blk = '0;
  logic [NB-1:0] ld_be = '0;
  logic [31:0] ld_data;
  logic rd_req = 1'b0, rd_gnt;
  logic [AW-1:0] rd_blk = '0;
  logic mem_valid, mem_we, mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [NB-1:0] mem_be;
  logic [31:0] mem_wdata;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  // drain log
  logic [AW-1:0] log_addr [16];
  logic [NB-1:0] log_be   [16];
  logic [31:0]   log_data [16];
  int log_n = 0;

  always #5 clk = ~clk;

  cwb_buffer #(.ENTRIES(E), .NB(NB), .AW(AW), .IDLE_CYC(IC)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_hwm(cfg_hwm),
    .st_valid(st_valid), .st_ready(st_ready), .st_blk(st_blk), .st_be(st_be), .st_data(st_data),
    .ld_valid(ld_valid), .ld_blk(ld_blk), .ld_be(ld_be), .ld_hit(ld_hit), .ld_wait(ld_wait),
    .ld_data(ld_data), .rd_req(rd_req), .rd_blk(rd_blk), .rd_gnt(rd_gnt),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready));

  always begin
    @(negedge clk);
    #3;
    if (mem_valid && mem_we && mem_ready && log_n < 16) begin
      log_addr[log_n] = mem_addr;
      log_be[log_n]   = mem_be;
      log_data[log_n] = mem_wdata;
      log_n++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected byte-lane view of a merge, written independently
  function automatic logic [31:0] lanes(input logic [31:0] d, input logic [NB-1:0] m);
    logic [31:0] r = '0;
    for (int b = 0; b < NB; b++) if (m[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  task automatic do_store(input logic [AW-1:0] b, input logic [NB-1:0] be,
                          input logic [31:0] d, input logic exp_rdy, input string req);
    @(negedge clk);
    st_valid = 1'b1; st_blk = b; st_be = be; st_data = d;
    #2 chk(req, 64'(st_ready), 64'(exp_rdy));
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic do_load(input logic [AW-1:0] b, input logic [NB-1:0] be,
                         output logic h, output logic w, output logic [31:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_blk = b; ld_be = be;
    #2 h = ld_hit; w = ld_wait; d = ld_data;
    ld_valid = 1'b0;
  endtask

  task automatic drain_all();
    @(negedge clk);
    cfg_hwm = '0; mem_ready = 1'b1;
    repeat (8) @(negedge clk);
    mem_ready = 1'b0; cfg_hwm = 3'd7;
    #2 chk("R2 drained empty", 64'(mem_valid), 64'd0);
  endtask

  task automatic t_reset();
    logic h, w; logic [31:0] d;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2 chk("R1 st_ready", 64'(st_ready), 64'd1);
    chk("R1 mem_valid", 64'(mem_valid), 64'd0);
    do_load(8'h10, 4'hF, h, w, d);
    chk("R1 ld_hit", 64'(h), 64'd0);
    chk("R1 ld_wait", 64'(w), 64'd0);
  endtask

  task automatic t_merge();
    logic h, w; logic [31:0] d;
    do_store(8'h10, 4'b0011, 32'h0000BBAA, 1'b1, "R2 alloc");
    do_store(8'h10, 4'b0100, 32'h00CC0000, 1'b1, "R3 merge");
    do_store(8'h10, 4'b0001, 32'h000000DD, 1'b1, "R3 overwrite");
    do_load(8'h10, 4'b0111, h, w, d);
    chk("R4 hit", 64'(h), 64'd1);
    chk("R3 merged data", 64'(lanes(d, 4'b0111)), 64'h00CCBBDD);
    do_load(8'h11, 4'hF, h, w, d);
    chk("R4 miss hit", 64'(h), 64'd0);
    chk("R4 miss wait", 64'(w), 64'd0);
    do_load(8'h10, 4'hF, h, w, d);
    chk("R5 partial wait", 64'(w), 64'd1);
    chk("R5 partial no hit", 64'(h), 64'd0);
  endtask

  task automatic t_readprio();
    log_n = 0;
    @(negedge clk);
    rd_req = 1'b1; rd_blk = 8'h55; mem_ready = 1'b1;
    #2 chk("R9 valid", 64'(mem_valid), 64'd1);
    chk("R9 we", 64'(mem_we), 64'd0);
    chk("R9 addr", 64'(mem_addr), 64'h55);
    chk("R9 be", 64'(mem_be), 64'hF);
    chk("R9 gnt", 64'(rd_gnt), 64'd1);
    @(negedge clk);
    rd_req = 1'b0; mem_ready = 1'b0;
    #4 chk("R9 no drain under read", 64'(log_n), 64'd0);
  endtask

  task automatic t_partial_drain();
    log_n = 0;
    @(negedge clk);
    ld_valid = 1'b1; ld_blk = 8'h10; ld_be = 4'hF; mem_ready = 1'b1;
    #2 chk("R5 forced drain", 64'(mem_we), 64'd1);
    chk("R10 addr", 64'(mem_addr), 64'h10);
    chk("R10 be", 64'(mem_be), 64'h7);
    chk("R10 data", 64'(lanes(mem_wdata, 4'b0111)), 64'h00CCBBDD);
    @(negedge clk);
    mem_ready = 1'b0;
    #2 chk("R5 after drain wait", 64'(ld_wait), 64'd0);
    chk("R5 after drain hit", 64'(ld_hit), 64'd0);
    ld_valid = 1'b0;
    chk("R10 one drain", 64'(log_n), 64'd1);
  endtask

  task automatic t_fill();
    log_n = 0;
    for (int i = 0; i < E; i++)
      do_store(AW'(8'h20 + i), 4'hF, 32'h10000000 + i, 1'b1, "R2 fill");
    do_store(8'h30, 4'hF, 32'h0, 1'b0, "R6 stall when full");
    do_store(8'h21, 4'b1000, 32'h77000000, 1'b1, "R6 merge when full");
    @(negedge clk);
    cfg_hwm = 3'd4; mem_ready = 1'b1;
    #2 chk("R7 at mark", 64'(mem_we), 64'd1);
    chk("R2 oldest first", 64'(mem_addr), 64'h20);
    repeat (12) @(negedge clk);
    mem_ready = 1'b0; cfg_hwm = 3'd7;
    chk("R2 drain count", 64'(log_n), 64'd4);
    for (int i = 0; i < E; i++)
      chk("R2 drain order", 64'(log_addr[i]), 64'(8'h20 + i));
    chk("R3 merged drain", 64'(log_data[1]), 64'h77000001);
    chk("R6 stalled not taken", 64'(mem_valid), 64'd0);
  endtask

  task automatic t_hwm_idle();
    @(negedge clk);
    cfg_hwm = 3'd3;
    do_store(8'h40, 4'hF, 32'h1, 1'b1, "R7 st");
    do_store(8'h41, 4'hF, 32'h2, 1'b1, "R7 st");
    #2 chk("R7 below mark", 64'(mem_valid), 64'd0);
    cfg_hwm = 3'd2;
    #1 chk("R7 reached mark", 64'(mem_we), 64'd1);
    cfg_hwm = 3'd7;
    #1 chk("R7 raised mark", 64'(mem_valid), 64'd0);
    for (int k = 1; k <= IC; k++) begin
      @(negedge clk);
      #2;
      if (k == IC - 1) chk("R8 not yet idle", 64'(mem_valid), 64'd0);
      if (k == IC)     chk("R8 idle drain", 64'(mem_we), 64'd1);
    end
    drain_all();
  endtask

  task automatic t_head_merge();
    logic h, w; logic [31:0] d;
    log_n = 0;
    do_store(8'h50, 4'b0001, 32'h000000AA, 1'b1, "R11 st");
    @(negedge clk);
    cfg_hwm = 3'd1; mem_ready = 1'b1;
    st_valid = 1'b1; st_blk = 8'h50; st_be = 4'b0010; st_data = 32'h0000BB00;
    #2 chk("R11 accepted", 64'(st_ready), 64'd1);
    @(negedge clk);
    st_valid = 1'b0; mem_ready = 1'b0; cfg_hwm = 3'd7;
    #4 chk("R11 old drained", 64'(log_be[0]), 64'h1);
    do_load(8'h50, 4'b0010, h, w, d);
    chk("R11 new slot hit", 64'(h), 64'd1);
    chk("R11 new slot data", 64'(d[15:8]), 64'hBB);
    do_load(8'h50, 4'b0001, h, w, d);
    chk("R11 old byte absent", 64'(w), 64'd1);
    drain_all();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_merge();
    t_readprio();
    t_partial_drain();
    t_fill();
    t_hwm_idle();
    t_head_merge();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule